// File: doc/BRIEF.md
# Pulse-Per-Second Time Counter

This block keeps time of day in a reference clock domain. A sub-second counter counts reference clock cycles from zero up to one less than the number of cycles in a second. When it wraps, a 40-bit seconds counter steps by one. The seconds counter is a plain count of seconds and has no leap-second handling. Each time the cycle counter rolls over, the block can emit a pulse on a pulse-per-second output. The pulse width is programmable, and a software-controlled qualifier enables the pulse. A second qualifier reports that the time is valid.

Software drives the block through a synchronous word-addressed register port. It writes staged seconds and cycle values first. It then sets a request bit, which either loads the staged values into the counters or adds them to the running counters as signed offsets. A load can cover both counters or only one of them. An offset that pushes the cycle counter past the end of a second, or below zero, carries into or borrows from the seconds counter. Request bits clear themselves when the hardware has acted on them, so software polls them to learn when the request is done. Counter reads are live and are not latched together. A coherent time is obtained by reading the seconds, then the cycles, then the seconds again, until the two seconds reads agree.

Word map (3-bit address): 0 control, 1 extended control, 2 staged seconds low, 3 staged seconds high, 4 staged cycles, 5 live seconds low, 6 live seconds high, 7 live cycles.

Top module: `ppsTimeCounter`

## Requirements
- R1: After reset every register and both counters are zero, `ppsOut` and `timeValid` are low, and the control and extended-control words read as zero.
- R2: While the count-enable bit (control bit 0) is 1, the cycle counter advances by one every clock. While it is 0, and no request is pending, both counters hold their values.
- R3: When the cycle counter is at CYCLES_PER_SEC-1 and counting is enabled, the next clock sets it to 0 and adds one to the seconds counter.
- R4: Writing 1 to the load-all bit (control bit 1) copies the staged seconds and staged cycles into the counters on the clock after the write. The bit reads back 1 until that clock and 0 after it.
- R5: Extended-control bit 0 loads only the seconds counter from the staged seconds, and bit 1 loads only the cycle counter from the staged cycles. Each is acted on the clock after the write and then clears itself. Meanwhile the other counter keeps its normal behaviour.
- R6: Writing 1 to the adjust bit (control bit 2) adds the staged seconds (40-bit two's complement) and the staged cycles (28-bit two's complement) to the running counters. The bit reads 1 until the addition is made and 0 after it.
- R7: If an adjustment takes the cycle sum to CYCLES_PER_SEC or more, CYCLES_PER_SEC is subtracted from it and one more second is added. If the sum falls below zero, CYCLES_PER_SEC is added to it and one second is taken away.
- R8: When a load and an adjust are both pending, the load is made first and the adjust is made on the following clock, against the loaded values.
- R9: Writing 0 to a request bit has no effect. Only the hardware clears request bits.
- R10: On a counting rollover (R3) that is neither replaced by a cycle load nor part of an adjustment, a pulse of W cycles starts. W is control bits [15:8]. `ppsOut` is high while the pulse runs and extended-control bit 2 is 1. When W is 0, no pulse is produced.
- R11: `timeValid` follows extended-control bit 3. Clearing extended-control bit 2 keeps `ppsOut` low.
- R12: A read returns data on `rdData` one clock after `rdEn`. The seconds high words hold the 8 upper bits in [7:0]. Cycle words hold 28 bits in [27:0]. Unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid one clock after rdEn |
| ppsOut | output | 1 | Pulse-per-second output |
| timeValid | output | 1 | Time-valid qualifier |

## Verification
The bench builds the block with CYCLES_PER_SEC set to 20 and keeps the default 40-bit seconds and 28-bit cycle widths. At that setting, rollovers, whole pulse periods and both carry and borrow on adjustment all happen within a few dozen clocks. With the full widths, a negative seconds offset wraps correctly into the 8-bit high word. With counting stopped, every load and adjust gives an exact expected value. Bursts of counting with a known length then check stepping and rollover.

// File: rtl/ppsTimePkg.sv
package ppsTimePkg;
  typedef struct packed {
    logic loadSec;
    logic loadCyc;
    logic adjust;
  } ppsStrobeT;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_EXT    = 3'd1;
  localparam logic [2:0] ADDR_STG_LO = 3'd2;
  localparam logic [2:0] ADDR_STG_HI = 3'd3;
  localparam logic [2:0] ADDR_STG_CY = 3'd4;
  localparam logic [2:0] ADDR_CUR_LO = 3'd5;
  localparam logic [2:0] ADDR_CUR_HI = 3'd6;
  localparam logic [2:0] ADDR_CUR_CY = 3'd7;
endpackage

// File: rtl/ppsCtrl.sv
module ppsCtrl
  import ppsTimePkg::*;
#(
  parameter int SEC_W = 40,
  parameter int CYC_W = 28,
  parameter int PW_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [2:0]       addr,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  input  logic [SEC_W-1:0] secNow,
  input  logic [CYC_W-1:0] cycNow,
  output ppsStrobeT        stb,
  output logic [SEC_W-1:0] stageSec,
  output logic [CYC_W-1:0] stageCyc,
  output logic [PW_W-1:0]  pulseWidth,
  output logic             cntEn,
  output logic             ppsValid,
  output logic             timeValidR
);
  localparam int HI_W = SEC_W - 32;

  logic reqLoadAll, reqAdj, reqLoadSec, reqLoadCyc;
  logic anyLoad, wrCtrl, wrExt;
  logic [31:0] rdMux;

  assign wrCtrl  = wrEn && (addr == ADDR_CTRL);
  assign wrExt   = wrEn && (addr == ADDR_EXT);
  assign anyLoad = reqLoadAll || reqLoadSec || reqLoadCyc;

  // loads win; a pending adjust waits one clock behind them
  always_comb begin
    stb.loadSec = reqLoadAll || reqLoadSec;
    stb.loadCyc = reqLoadAll || reqLoadCyc;
    stb.adjust  = reqAdj && !anyLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntEn      <= 1'b0;
      pulseWidth <= '0;
      reqLoadAll <= 1'b0;
      reqAdj     <= 1'b0;
      reqLoadSec <= 1'b0;
      reqLoadCyc <= 1'b0;
      ppsValid   <= 1'b0;
      timeValidR <= 1'b0;
      stageSec   <= '0;
      stageCyc   <= '0;
    end else begin
      reqLoadAll <= (reqLoadAll && !anyLoad) || (wrCtrl && wrData[1]);
      reqLoadSec <= (reqLoadSec && !anyLoad) || (wrExt && wrData[0]);
      reqLoadCyc <= (reqLoadCyc && !anyLoad) || (wrExt && wrData[1]);
      reqAdj     <= (reqAdj && !stb.adjust) || (wrCtrl && wrData[2]);
      if (wrCtrl) begin
        cntEn      <= wrData[0];
        pulseWidth <= wrData[8 +: PW_W];
      end
      if (wrExt) begin
        ppsValid   <= wrData[2];
        timeValidR <= wrData[3];
      end
      if (wrEn && addr == ADDR_STG_LO) stageSec[31:0]      <= wrData;
      if (wrEn && addr == ADDR_STG_HI) stageSec[SEC_W-1:32] <= wrData[HI_W-1:0];
      if (wrEn && addr == ADDR_STG_CY) stageCyc            <= wrData[CYC_W-1:0];
    end
  end

  always_comb begin
    rdMux = '0;
    case (addr)
      ADDR_CTRL: begin
        rdMux[0]         = cntEn;
        rdMux[1]         = reqLoadAll;
        rdMux[2]         = reqAdj;
        rdMux[8 +: PW_W] = pulseWidth;
      end
      ADDR_EXT: begin
        rdMux[0] = reqLoadSec;
        rdMux[1] = reqLoadCyc;
        rdMux[2] = ppsValid;
        rdMux[3] = timeValidR;
      end
      ADDR_STG_LO: rdMux             = stageSec[31:0];
      ADDR_STG_HI: rdMux[HI_W-1:0]   = stageSec[SEC_W-1:32];
      ADDR_STG_CY: rdMux[CYC_W-1:0]  = stageCyc;
      ADDR_CUR_LO: rdMux             = secNow[31:0];
      ADDR_CUR_HI: rdMux[HI_W-1:0]   = secNow[SEC_W-1:32];
      default:     rdMux[CYC_W-1:0]  = cycNow;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdMux;
  end

  // R6: an adjust that is issued clears its request unless software sets it again
  a_r6_adjust_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stb.adjust && !(wrCtrl && wrData[2])) |=> !reqAdj);

  // R8: an adjust waiting behind a load stays pending
  a_r8_adjust_waits: assert property (@(posedge clk) disable iff (!rstN)
    (reqAdj && anyLoad) |=> reqAdj);
endmodule

// File: rtl/ppsDatapath.sv
module ppsDatapath
  import ppsTimePkg::*;
#(
  parameter int CYCLES_PER_SEC = 125000000,
  parameter int SEC_W = 40,
  parameter int CYC_W = 28,
  parameter int PW_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  ppsStrobeT        stb,
  input  logic [SEC_W-1:0] stageSec,
  input  logic [CYC_W-1:0] stageCyc,
  input  logic [PW_W-1:0]  pulseWidth,
  input  logic             ppsEn,
  output logic [SEC_W-1:0] secCnt,
  output logic [CYC_W-1:0] cycCnt,
  output logic             ppsOut
);
  localparam int SUM_W = CYC_W + 2;
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(CYCLES_PER_SEC - 1);
  localparam logic signed [SUM_W-1:0] CPS_S = SUM_W'(CYCLES_PER_SEC);

  logic natWrap;
  logic [CYC_W-1:0] cycNext;
  logic [SEC_W-1:0] secNext;
  logic signed [SUM_W-1:0] sumS, adjCyc;
  logic [SEC_W-1:0] carry, adjSec;
  logic [PW_W-1:0] pulseCnt;
  logic pulseActive;

  assign natWrap = cntEn && (cycCnt == LAST_CYC);
  assign cycNext = natWrap ? '0 : cycCnt + CYC_W'(cntEn);
  assign secNext = natWrap ? secCnt + SEC_W'(1) : secCnt;

  // signed offset applied on top of this clock's count step
  always_comb begin
    sumS = $signed({2'b00, cycCnt}) + $signed(SUM_W'(cntEn))
         + $signed({{2{stageCyc[CYC_W-1]}}, stageCyc});
    if (sumS >= CPS_S) begin
      adjCyc = sumS - CPS_S;
      carry  = SEC_W'(1);
    end else if (sumS < 0) begin
      adjCyc = sumS + CPS_S;
      carry  = {SEC_W{1'b1}};
    end else begin
      adjCyc = sumS;
      carry  = '0;
    end
    adjSec = secCnt + stageSec + carry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secCnt <= '0;
      cycCnt <= '0;
    end else if (stb.loadSec || stb.loadCyc) begin
      secCnt <= stb.loadSec ? stageSec : secNext;
      cycCnt <= stb.loadCyc ? stageCyc : cycNext;
    end else if (stb.adjust) begin
      secCnt <= adjSec;
      cycCnt <= adjCyc[CYC_W-1:0];
    end else begin
      secCnt <= secNext;
      cycCnt <= cycNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      pulseCnt <= '0;
    else if (natWrap && !stb.loadCyc && !stb.adjust)
      pulseCnt <= pulseWidth;
    else if (pulseCnt != '0)
      pulseCnt <= pulseCnt - PW_W'(1);
  end

  assign pulseActive = (pulseCnt != '0);
  assign ppsOut      = ppsEn && pulseActive;

  // R3: plain rollover clears the cycles and steps the seconds
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (natWrap && stb == '0) |=> (cycCnt == '0 && secCnt == $past(secCnt) + SEC_W'(1)));

  // R2: with counting off and no request both counters hold
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && stb == '0) |=> ($stable(cycCnt) && $stable(secCnt)));

  // R10: a pulse only begins at the start of a second
  a_r10_pulse_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseActive) |-> (cycCnt == '0));

  // R5: a cycle load lands the staged value
  a_r5_load_cyc: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCyc |=> (cycCnt == $past(stageCyc)));
endmodule

// File: rtl/ppsTimeCounter.sv
module ppsTimeCounter
  import ppsTimePkg::*;
#(
  parameter int CYCLES_PER_SEC = 125000000,
  parameter int SEC_W = 40,
  parameter int CYC_W = 28,
  parameter int PW_W  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        ppsOut,
  output logic        timeValid
);
  ppsStrobeT        stb;
  logic [SEC_W-1:0] stageSec, secCnt;
  logic [CYC_W-1:0] stageCyc, cycCnt;
  logic [PW_W-1:0]  pulseWidth;
  logic             cntEn, ppsValid;

  ppsCtrl #(.SEC_W(SEC_W), .CYC_W(CYC_W), .PW_W(PW_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .secNow(secCnt), .cycNow(cycCnt),
    .stb(stb), .stageSec(stageSec), .stageCyc(stageCyc),
    .pulseWidth(pulseWidth), .cntEn(cntEn), .ppsValid(ppsValid),
    .timeValidR(timeValid)
  );

  ppsDatapath #(.CYCLES_PER_SEC(CYCLES_PER_SEC), .SEC_W(SEC_W),
                .CYC_W(CYC_W), .PW_W(PW_W)) uData (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .stb(stb),
    .stageSec(stageSec), .stageCyc(stageCyc), .pulseWidth(pulseWidth),
    .ppsEn(ppsValid), .secCnt(secCnt), .cycCnt(cycCnt), .ppsOut(ppsOut)
  );
endmodule

// File: tb/tb_ppsTimeCounter.sv
module tb_ppsTimeCounter;
  localparam int CPS = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic ppsOut, timeValid;

  int nChecks = 0, nFails = 0;
  bit rdIssued = 1'b0;
  bit done = 1'b0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  ppsTimeCounter #(.CYCLES_PER_SEC(CPS)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ppsOut(ppsOut), .timeValid(timeValid)
  );

  // monitor: compare each read result against the scoreboard
  always @(posedge clk) rdIssued <= rdEn;
  always @(negedge clk) begin
    if (rdIssued && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChecks++;
      if (rdData !== e) begin
        nFails++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", t, rdData, e);
      end
    end
  end

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    rdEn = 1'b1; addr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stage(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] cy);
    wr(3'd2, lo);
    wr(3'd3, hi);
    wr(3'd4, cy);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    int highs, period;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 ppsOut", ppsOut, 0);
    check("R1 timeValid", timeValid, 0);
    rd(3'd0, 32'h0, "R1 ctrl");
    rd(3'd1, 32'h0, "R1 ext");
    rd(3'd5, 32'h0, "R1 sec");
    rd(3'd7, 32'h0, "R1 cyc");

    // R4 load all, busy readback
    stage(32'd100, 32'h12, 32'd15);
    wr(3'd0, 32'h302);
    rd(3'd0, 32'h302, "R4 pending");
    rd(3'd0, 32'h300, "R4 cleared");
    rd(3'd5, 32'd100, "R4 sec lo");
    rd(3'd6, 32'h12, "R4 sec hi R12");
    rd(3'd7, 32'd15, "R4 cyc");

    // R9 writing zero to request bits does nothing
    wr(3'd0, 32'h300);
    idle(3);
    rd(3'd7, 32'd15, "R9 cyc");
    rd(3'd5, 32'd100, "R9 sec");

    // R2 three counting clocks, then hold
    wr(3'd0, 32'h301);
    idle(2);
    wr(3'd0, 32'h300);
    rd(3'd7, 32'd18, "R2 count");
    idle(5);
    rd(3'd7, 32'd18, "R2 hold");
    rd(3'd5, 32'd100, "R2 sec");

    // R3 rollover: 18,19,0,1
    wr(3'd0, 32'h301);
    idle(2);
    wr(3'd0, 32'h300);
    rd(3'd7, 32'd1, "R3 cyc");
    rd(3'd5, 32'd101, "R3 sec lo");
    rd(3'd6, 32'h12, "R3 sec hi");

    // R5 partial loads
    stage(32'd77, 32'h0, 32'd9);
    wr(3'd1, 32'h1);
    idle(1);
    rd(3'd5, 32'd77, "R5 sec only lo");
    rd(3'd6, 32'h0, "R5 sec only hi");
    rd(3'd7, 32'd1, "R5 cyc untouched");
    wr(3'd1, 32'h2);
    rd(3'd1, 32'h2, "R5 pending");
    rd(3'd1, 32'h0, "R5 cleared");
    rd(3'd7, 32'd9, "R5 cyc only");
    rd(3'd5, 32'd77, "R5 sec untouched");

    // R6 R7 adjust with carry: 9+14=23 -> 3, 77+2+1
    stage(32'd2, 32'h0, 32'd14);
    wr(3'd0, 32'h304);
    rd(3'd0, 32'h304, "R6 busy");
    rd(3'd0, 32'h300, "R6 done");
    rd(3'd7, 32'd3, "R7 carry cyc");
    rd(3'd5, 32'd80, "R7 carry sec");

    // R7 borrow: 3-5 -> 18, 80-1-1
    stage(32'hFFFF_FFFF, 32'hFF, 32'h0FFF_FFFB);
    wr(3'd0, 32'h304);
    idle(1);
    rd(3'd7, 32'd18, "R7 borrow cyc");
    rd(3'd5, 32'd78, "R7 borrow sec lo");
    rd(3'd6, 32'h0, "R7 borrow sec hi");

    // R6 negative seconds offset: 78-100 wraps the 40-bit count
    stage(32'hFFFF_FF9C, 32'hFF, 32'h0);
    wr(3'd0, 32'h304);
    idle(1);
    rd(3'd5, 32'hFFFF_FFEA, "R6 neg sec lo");
    rd(3'd6, 32'hFF, "R6 neg sec hi");
    rd(3'd7, 32'd18, "R6 cyc kept");

    // R8 load then adjust: load 10/4, add 10/4
    stage(32'd10, 32'h0, 32'd4);
    wr(3'd0, 32'h306);
    rd(3'd0, 32'h306, "R8 both pending");
    rd(3'd0, 32'h304, "R8 adjust waits");
    rd(3'd0, 32'h300, "R8 all done");
    rd(3'd7, 32'd8, "R8 cyc");
    rd(3'd5, 32'd20, "R8 sec");

    // R12 staged readback and masking
    wr(3'd3, 32'hFFFF_FF12);
    rd(3'd3, 32'h12, "R12 hi mask");
    rd(3'd4, 32'd4, "R12 stage cyc");

    // R11 time valid qualifier
    wr(3'd1, 32'h8);
    check("R11 timeValid", timeValid, 1);
    check("R11 ppsOut off", ppsOut, 0);

    // R10 pulse width 3 and period
    stage(32'd0, 32'h0, 32'd17);
    wr(3'd0, 32'h302);
    idle(1);
    wr(3'd1, 32'hC);
    wr(3'd0, 32'h301);
    for (int i = 0; i < 60; i++) begin
      if (ppsOut) break;
      @(negedge clk);
    end
    check("R10 pulse seen", ppsOut, 1);
    highs = 1;
    forever begin
      @(negedge clk);
      if (ppsOut) highs++;
      else break;
    end
    check("R10 width", highs, 3);
    period = highs;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      period++;
      if (ppsOut) break;
    end
    check("R10 period", period, CPS);

    // R11 pulse gated off by the valid bit
    wr(3'd1, 32'h8);
    highs = 0;
    for (int i = 0; i < 2 * CPS; i++) begin
      @(negedge clk);
      if (ppsOut) highs++;
    end
    check("R11 gated", highs, 0);
    check("R11 timeValid held", timeValid, 1);

    // R10 width zero gives no pulse
    wr(3'd0, 32'h001);
    idle(CPS + 2);
    wr(3'd1, 32'hC);
    highs = 0;
    for (int i = 0; i < 2 * CPS + 2; i++) begin
      @(negedge clk);
      if (ppsOut) highs++;
    end
    check("R10 zero width", highs, 0);

    idle(3);
    done = 1'b1;
    summary();
  end
endmodule